// File: doc/BRIEF.md
# Ping-Pong Host Interface Buffer

This block sits between an on-chip CPU and an external host and holds two banks of shared word storage. At any moment one bank belongs to the host, which drains it through a small register window, and the other belongs to the CPU, which fills it. When the CPU has filled its bank, it writes a trigger bit. The banks then change owners, the CPU receives a sticky bank interrupt so it can refill the bank it now holds, and a DMA request goes out to the host so it can drain the fresh data.

The host side has an address register, a mode register, a data register and a status register. A separate register-select pin picks the status register directly. After the host writes a start offset and arms consecutive mode, each data-register read returns the next word of its bank. Streaming halts after the last word of the bank and picks up again at word 0 when the next bank switch arrives. A host access to any other register cancels streaming. The one exception is a status read with register-select low, so the host can poll without losing its place.

The host engine is a three-state machine. HS_IDLE means no streaming. HS_STREAM means each data read advances the pointer. HS_DRAINED means the last word has been read and the engine is waiting for a switch. Its transitions are:
- arm: a mode write with bit 0 set, from any state, leads to HS_STREAM.
- end-of-bank: a data read of the last word leads from HS_STREAM to HS_DRAINED.
- abort: a stray access leads from HS_STREAM or HS_DRAINED to HS_IDLE.
- switch: a bank switch leads from HS_STREAM or HS_DRAINED to HS_STREAM at word 0, and from HS_IDLE back to HS_IDLE at word 0.

Top module: `pingpong_hbuf`

## Requirements
- R1: After reset the host owns bank 0 and the CPU owns bank 1. The interrupt and the DMA request are low, and the host engine is idle with its pointer at word 0.
- R2: A CPU control write with bit 0 set swaps bank ownership on the next edge. In the control readback, bit 0 (the trigger) always reads 0, bit 1 is the interrupt flag and bit 2 is the bank the CPU owns.
- R3: Every swap sets the sticky interrupt flag. A control write with bit 1 set clears it, but a swap in the same cycle wins. A swap is honoured while the flag is already set.
- R4: Every swap raises the DMA request. The request stays high until the host's first data-register read after the swap.
- R5: Host register map: register-select high with select 0 is the address, 1 is the mode, 2 is the data and 3 is a status mirror. Register-select low is the status register. Writing an offset to the address register and then writing the mode with bit 0 set starts streaming. Each data read then returns the next word, with the read data valid one cycle after the access.
- R6: After the word at the last offset is read, streaming stops (HS_DRAINED). Further data reads return that last word without advancing.
- R7: A swap resets the pointer to word 0 of the host's new bank. If the engine was streaming or drained, streaming resumes with no new setup.
- R8: Any host access other than a data-register access or a status read with register-select low ends streaming (HS_IDLE). This includes status writes and status-mirror reads. Outside streaming, data reads return the word at the pointer without advancing it.
- R9: Status word: bit 0 is the DMA request, bit 1 is streaming, bit 2 is the host's bank and the upper bits are 0. A status read with register-select low leaves streaming undisturbed.
- R10: A host data write stores the word at the pointer in the host's bank. It neither advances the pointer nor ends streaming or the drained state.
- R11: CPU writes go to the CPU's bank. The CPU read data shows the word at the CPU address from the CPU's bank one cycle later, and CPU writes never alter the host's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_we | input | 1 | CPU word write strobe |
| cpu_addr | input | AW | CPU word offset in its bank |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data, one cycle latency |
| cpu_ctl_wr | input | 1 | CPU control write strobe |
| cpu_ctl_wdata | input | 2 | Bit 0 trigger, bit 1 interrupt clear |
| cpu_ctl_rdata | output | 3 | Control readback |
| cpu_irq | output | 1 | Sticky bank interrupt |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | Host write (1) or read (0) |
| host_rs | input | 1 | Register select (low picks status) |
| host_sel | input | 2 | Register index when register-select is high |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, valid one cycle after a read |
| host_dreq | output | 1 | DMA request toward the host |

## Verification
The bench builds the block with 16-bit words and 8-word banks (AW=3). The short banks let the host reach the last offset, the drained state and the resume-after-switch path within a handful of reads. The narrow words let the status and pointer readbacks be compared as small literal values. Over three fill-and-swap rounds the bench covers a swap while the interrupt is still set, a simultaneous clear and swap, streaming from a nonzero start offset, and a host write into the drained bank that the CPU later reads back.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_STREAM  = 2'd1,
        HS_DRAINED = 2'd2
    } hstate_e;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

endpackage

// File: rtl/hbuf_banks.sv
module hbuf_banks #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          host_bank,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_word
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] rd_host [2];
    logic [DW-1:0] rd_cpu  [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [DW-1:0] cells [DEPTH];
        // The CPU owns this bank when the host does not.
        logic          own_host;
        logic          wen;
        logic [AW-1:0] waddr;
        logic [DW-1:0] wdat;

        assign own_host = (host_bank == 1'(b));
        assign wen      = own_host ? host_we : cpu_we;
        assign waddr    = own_host ? host_addr : cpu_addr;
        assign wdat     = own_host ? host_wdata : cpu_wdata;

        always_ff @(posedge clk) begin
            if (wen) begin
                cells[waddr] <= wdat;
            end
        end

        assign rd_host[b] = cells[host_addr];
        assign rd_cpu[b]  = cells[cpu_addr];
    end

    assign host_word = rd_host[host_bank];

    always_ff @(posedge clk) begin
        cpu_rdata <= rd_cpu[~host_bank];
    end

endmodule

// File: rtl/hbuf_owner.sv
module hbuf_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic irq_clr,
    input  logic host_data_rd,
    output logic swap,
    output logic host_bank,
    output logic irq,
    output logic dreq
);
    assign swap = trig;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_bank <= 1'b0;
            irq       <= 1'b0;
            dreq      <= 1'b0;
        end else begin
            if (swap) begin
                host_bank <= ~host_bank;
            end
            // A swap in the same cycle beats an interrupt clear.
            if (swap) begin
                irq <= 1'b1;
            end else if (irq_clr) begin
                irq <= 1'b0;
            end
            if (swap) begin
                dreq <= 1'b1;
            end else if (host_data_rd) begin
                dreq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hbuf_host_regs.sv
module hbuf_host_regs
    import hbuf_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_cs,
    input  logic          host_we,
    input  logic          host_rs,
    input  logic [1:0]    host_sel,
    input  logic [AW-1:0] addr_in,
    input  logic          swap,
    input  logic          host_bank,
    input  logic          dreq,
    input  logic [DW-1:0] mem_word,
    output logic [DW-1:0] host_rdata,
    output logic          data_rd,
    output logic          data_wr,
    output logic [AW-1:0] ptr,
    output hstate_e       state
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    hstate_e       st_n;
    logic [AW-1:0] ptr_n;
    logic          is_data;
    logic          arm;
    logic          addr_wr;
    logic          quiet_stat;
    logic          stray;
    logic          streaming;
    logic [DW-1:0] status_word;

    // Access decode.
    always_comb begin
        is_data    = host_rs && (host_sel == SEL_DATA);
        data_rd    = host_cs && !host_we && is_data;
        data_wr    = host_cs && host_we && is_data;
        arm        = host_cs && host_we && host_rs && (host_sel == SEL_MODE) && addr_in[0];
        addr_wr    = host_cs && host_we && host_rs && (host_sel == SEL_ADDR);
        quiet_stat = host_cs && !host_we && !host_rs;
        stray      = host_cs && !is_data && !quiet_stat;
    end

    // Next state and pointer.
    always_comb begin
        st_n  = state;
        ptr_n = ptr;
        if (addr_wr) begin
            ptr_n = addr_in;
        end
        unique case (state)
            HS_IDLE: begin
                if (arm) begin
                    st_n = HS_STREAM;
                end
            end
            HS_STREAM: begin
                if (arm) begin
                    st_n = HS_STREAM;
                end else if (stray) begin
                    st_n = HS_IDLE;
                end else if (data_rd) begin
                    if (ptr == LAST) begin
                        st_n = HS_DRAINED;
                    end else begin
                        ptr_n = ptr + 1'b1;
                    end
                end
            end
            HS_DRAINED: begin
                if (arm) begin
                    st_n = HS_STREAM;
                end else if (stray) begin
                    st_n = HS_IDLE;
                end
            end
            default: st_n = HS_IDLE;
        endcase
        if (swap) begin
            ptr_n = '0;
            st_n  = (state == HS_IDLE) ? HS_IDLE : HS_STREAM;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HS_IDLE;
            ptr   <= '0;
        end else begin
            state <= st_n;
            ptr   <= ptr_n;
        end
    end

    assign streaming   = (state == HS_STREAM);
    assign status_word = {{(DW-3){1'b0}}, host_bank, streaming, dreq};

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_cs && !host_we) begin
            if (!host_rs) begin
                host_rdata <= status_word;
            end else begin
                unique case (host_sel)
                    SEL_ADDR: host_rdata <= {{(DW-AW){1'b0}}, ptr};
                    SEL_MODE: host_rdata <= {{(DW-1){1'b0}}, streaming};
                    SEL_DATA: host_rdata <= mem_word;
                    SEL_STAT: host_rdata <= status_word;
                endcase
            end
        end
    end

endmodule

// File: rtl/pingpong_hbuf.sv
module pingpong_hbuf
    import hbuf_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    input  logic          cpu_ctl_wr,
    input  logic [1:0]    cpu_ctl_wdata,
    output logic [2:0]    cpu_ctl_rdata,
    output logic          cpu_irq,
    input  logic          host_cs,
    input  logic          host_we,
    input  logic          host_rs,
    input  logic [1:0]    host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_dreq
);
    logic          swap;
    logic          host_bank;
    logic          data_rd;
    logic          data_wr;
    logic [AW-1:0] ptr;
    logic [DW-1:0] mem_word;
    hstate_e       host_state;

    hbuf_owner u_owner (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig         (cpu_ctl_wr && cpu_ctl_wdata[0]),
        .irq_clr      (cpu_ctl_wr && cpu_ctl_wdata[1]),
        .host_data_rd (data_rd),
        .swap         (swap),
        .host_bank    (host_bank),
        .irq          (cpu_irq),
        .dreq         (host_dreq)
    );

    hbuf_host_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_cs    (host_cs),
        .host_we    (host_we),
        .host_rs    (host_rs),
        .host_sel   (host_sel),
        .addr_in    (host_wdata[AW-1:0]),
        .swap       (swap),
        .host_bank  (host_bank),
        .dreq       (host_dreq),
        .mem_word   (mem_word),
        .host_rdata (host_rdata),
        .data_rd    (data_rd),
        .data_wr    (data_wr),
        .ptr        (ptr),
        .state      (host_state)
    );

    hbuf_banks #(.DW(DW), .AW(AW)) u_banks (
        .clk        (clk),
        .host_bank  (host_bank),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .host_we    (data_wr),
        .host_addr  (ptr),
        .host_wdata (host_wdata),
        .host_word  (mem_word)
    );

    assign cpu_ctl_rdata = {~host_bank, cpu_irq, 1'b0};

endmodule

// File: rtl/hbuf_checker.sv
module hbuf_checker
    import hbuf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_ctl_wr,
    input logic [1:0] cpu_ctl_wdata,
    input logic       cpu_bank,
    input logic       cpu_irq,
    input logic       host_dreq,
    input logic       host_cs,
    input logic       host_we,
    input logic       host_rs,
    input logic [1:0] host_sel,
    input logic       mode_bit,
    input hstate_e    host_state
);
    logic trig;
    logic clr;
    logic drd;
    logic stray;
    logic arm;

    assign trig  = cpu_ctl_wr && cpu_ctl_wdata[0];
    assign clr   = cpu_ctl_wr && cpu_ctl_wdata[1];
    assign drd   = host_cs && !host_we && host_rs && (host_sel == SEL_DATA);
    assign arm   = host_cs && host_we && host_rs && (host_sel == SEL_MODE) && mode_bit;
    assign stray = host_cs && !(host_rs && (host_sel == SEL_DATA)) && !(!host_we && !host_rs);

    assert_swap_toggles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cpu_bank != $past(cpu_bank)));

    assert_bank_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(cpu_bank));

    assert_irq_on_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> cpu_irq);

    assert_irq_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq && !clr) |=> cpu_irq);

    assert_dreq_on_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> host_dreq);

    assert_dreq_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_dreq && drd && !trig) |=> !host_dreq);

    assert_drained_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_state == HS_DRAINED && !trig && !host_cs) |=> (host_state == HS_DRAINED));

    assert_stray_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stray && !arm && !trig) |=> (host_state == HS_IDLE));

endmodule

bind pingpong_hbuf hbuf_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_ctl_wr    (cpu_ctl_wr),
    .cpu_ctl_wdata (cpu_ctl_wdata),
    .cpu_bank      (cpu_ctl_rdata[2]),
    .cpu_irq       (cpu_irq),
    .host_dreq     (host_dreq),
    .host_cs       (host_cs),
    .host_we       (host_we),
    .host_rs       (host_rs),
    .host_sel      (host_sel),
    .mode_bit      (host_wdata[0]),
    .host_state    (host_state)
);

// File: tb/pingpong_hbuf_test.sv
`timescale 1ns/1ps
module pingpong_hbuf_test;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ctl_wr = 1'b0;
    logic [1:0]    cpu_ctl_wdata = '0;
    logic [2:0]    cpu_ctl_rdata;
    logic          cpu_irq;
    logic          host_cs = 1'b0;
    logic          host_we = 1'b0;
    logic          host_rs = 1'b0;
    logic [1:0]    host_sel = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          host_dreq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] exp_q[$];
    string         tag_q[$];

    always #2 clk = ~clk;

    pingpong_hbuf #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ctl_wr(cpu_ctl_wr), .cpu_ctl_wdata(cpu_ctl_wdata), .cpu_ctl_rdata(cpu_ctl_rdata),
        .cpu_irq(cpu_irq),
        .host_cs(host_cs), .host_we(host_we), .host_rs(host_rs), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_dreq(host_dreq)
    );

    function automatic logic [DW-1:0] word(int r, int i);
        return DW'(r * 256 + i);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: compares each host read result one cycle after the access.
    always begin
        logic rd_now;
        @(posedge clk);
        rd_now = host_cs && !host_we;
        #1;
        if (rd_now) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL scoreboard actual=%0h expected=none", host_rdata);
            end else begin
                chk(tag_q.pop_front(), 32'(host_rdata), 32'(exp_q.pop_front()));
            end
        end
    end

    task automatic host_acc(logic we, logic rs, logic [1:0] sel, logic [DW-1:0] d);
        @(negedge clk);
        host_cs = 1'b1; host_we = we; host_rs = rs; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(logic rs, logic [1:0] sel, logic [DW-1:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        host_acc(1'b0, rs, sel, '0);
    endtask

    task automatic hwrite(logic rs, logic [1:0] sel, logic [DW-1:0] d);
        host_acc(1'b1, rs, sel, d);
    endtask

    task automatic cpu_fill(int r);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            cpu_we = 1'b1; cpu_addr = AW'(i); cpu_wdata = word(r, i);
        end
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_ctl(logic [1:0] v);
        @(negedge clk);
        cpu_ctl_wr = 1'b1; cpu_ctl_wdata = v;
        @(negedge clk);
        cpu_ctl_wr = 1'b0; cpu_ctl_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq", 32'(cpu_irq), 0);
        chk("R1 dreq", 32'(host_dreq), 0);
        chk("R1 ctl readback", 32'(cpu_ctl_rdata), 32'b100);
        hread(1'b0, 2'd0, 0, "R1 status");
        hread(1'b1, 2'd0, 0, "R1 pointer");

        // Round 1: CPU fills bank 1 and hands it over.
        cpu_fill(1);
        cpu_ctl(2'b01);
        chk("R2 ctl after swap", 32'(cpu_ctl_rdata), 32'b010);
        chk("R3 irq set", 32'(cpu_irq), 1);
        chk("R4 dreq set", 32'(host_dreq), 1);
        hwrite(1'b1, 2'd0, 0);
        hwrite(1'b1, 2'd1, 1);
        hread(1'b0, 2'd0, 7, "R9 status while streaming");
        for (int i = 0; i < N; i++) begin
            hread(1'b1, 2'd2, word(1, i), "R5 stream word");
            if (i == 0) chk("R4 dreq dropped", 32'(host_dreq), 0);
        end
        hread(1'b0, 2'd0, 4, "R6 status drained");
        cpu_fill(2);
        hread(1'b1, 2'd2, word(1, N - 1), "R6 read after end, R11 host bank untouched");

        // Round 2: swap while the interrupt is still pending.
        cpu_ctl(2'b01);
        chk("R3 swap honoured with irq set", 32'(cpu_ctl_rdata), 32'b110);
        for (int i = 0; i < 3; i++) begin
            hread(1'b1, 2'd2, word(2, i), "R7 resume at word 0");
        end
        hread(1'b1, 2'd0, 3, "R8 address read");
        hread(1'b0, 2'd0, 0, "R8 aborted status");
        hread(1'b1, 2'd2, word(2, 3), "R8 idle data read");
        hread(1'b1, 2'd2, word(2, 3), "R8 idle no advance");
        hwrite(1'b1, 2'd1, 1);
        hread(1'b1, 2'd2, word(2, 3), "R5 rearmed");
        hread(1'b1, 2'd3, 2, "R8 mirror status read");
        hread(1'b0, 2'd0, 0, "R8 mirror aborted");
        hwrite(1'b1, 2'd1, 1);
        hwrite(1'b0, 2'd0, 16'h00ff);
        hread(1'b0, 2'd0, 0, "R8 status write aborted");
        hread(1'b1, 2'd2, word(2, 4), "R8 pointer kept");

        // Interrupt clear, then clear and swap together.
        cpu_ctl(2'b10);
        chk("R3 irq cleared", 32'(cpu_irq), 0);
        cpu_fill(3);
        cpu_ctl(2'b11);
        chk("R3 swap wins over clear", 32'(cpu_irq), 1);
        chk("R4 dreq round 3", 32'(host_dreq), 1);
        hread(1'b0, 2'd0, 5, "R9 status idle bank1 dreq");

        // Round 3: stream from a nonzero start offset.
        hwrite(1'b1, 2'd0, 5);
        hwrite(1'b1, 2'd1, 1);
        for (int i = 5; i < N; i++) begin
            hread(1'b1, 2'd2, word(3, i), "R5 offset stream");
        end
        hread(1'b0, 2'd0, 4, "R6 drained again");
        hread(1'b1, 2'd2, word(3, N - 1), "R6 end word repeats");
        hwrite(1'b1, 2'd2, 16'hbeef);
        hread(1'b1, 2'd2, 16'hbeef, "R10 host write stored");
        hread(1'b0, 2'd0, 4, "R10 still drained");

        // Hand bank 1 back to the CPU; host resumes bank 0.
        cpu_ctl(2'b01);
        @(negedge clk);
        cpu_addr = AW'(N - 1);
        @(negedge clk);
        chk("R11 cpu sees host write", 32'(cpu_rdata), 32'hbeef);
        cpu_addr = '0;
        @(negedge clk);
        chk("R11 cpu word 0", 32'(cpu_rdata), 32'(word(3, 0)));
        hread(1'b1, 2'd2, word(2, 0), "R7 resume from drained");
        hread(1'b1, 2'd2, word(2, 1), "R7 advance after resume");

        repeat (3) @(negedge clk);
        chk("scoreboard empty", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule